// File: doc/BRIEF.md
# ECC Error Capture Registers

This block records memory ECC error events so that software can inspect them later. An ECC checker sends it two single-cycle pulses, one for a correctable error and one for an uncorrectable error. Each pulse comes with the physical address that failed, the 8-bit syndrome and the channel number. The block keeps two sticky status flags. It also keeps one logged copy of the address page, the syndrome and the channel. Software reads all of this through a byte-wide register port and clears a flag by writing a one to it.

Only one set of error details is held at a time, so the block decides which event owns that set. An uncorrectable error takes over details that an earlier correctable error logged. A correctable error never displaces logged details. A second uncorrectable error leaves the first one's details in place. When a software clear and a new event land in the same cycle, the event wins. The capture decision is then made against the flags as they stand after the clear.

Top module: `ecc_err_log`

## Requirements
- R1: Reset clears both status flags and all logged fields, so every offset from 0x00 to 0x0F reads 0x00.
- R2: A correctable-error pulse sets status bit 0, read at offset 0x08.
- R3: An uncorrectable-error pulse sets status bit 7, read at offset 0x08.
- R4: Writing to offset 0x08 clears each status bit written as one and leaves the bits written as zero unchanged. Writing 0x81 clears both flags. Without a clear, a set flag stays set.
- R5: The error address pointer reads little-endian at offsets 0x00 to 0x03. Bits 31:12 hold the logged page and bits 11:0 read zero, so offset 0x00 always reads 0x00.
- R6: The syndrome reads at offset 0x04. The channel reads at offset 0x05 in bit 0, and bits 7:1 of that byte read zero.
- R7: When both flags are clear, a correctable error captures its page, syndrome and channel.
- R8: When only the correctable flag is set, an uncorrectable error replaces the logged page, syndrome and channel with its own, and bit 0 stays set.
- R9: While any status flag is set, a correctable error leaves the logged fields unchanged and only sets bit 0.
- R10: While the uncorrectable flag is set, another uncorrectable error leaves the logged fields unchanged.
- R11: When both pulses arrive in the same cycle, the uncorrectable error's details are captured and both flags are set.
- R12: When an event and a clear write fall in the same cycle, the event's flag ends set. Capture is judged against the flags after the clear has been applied.
- R13: Offsets 0x06, 0x07 and 0x09 to 0x0F read zero. Writes to any offset other than 0x08 and 0x09 have no effect.
- R14: Clearing status flags does not change the logged page, syndrome or channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_pulse | input | 1 | Correctable-error event, one cycle |
| ue_pulse | input | 1 | Uncorrectable-error event, one cycle |
| err_addr | input | 32 | Physical address of the failing access |
| err_syn | input | 8 | ECC syndrome of the event |
| err_chan | input | 1 | Channel that took the event |
| reg_addr | input | 4 | Register byte offset |
| reg_wr_en | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for reg_addr, combinational |

## Verification
The bench builds the block with its default parameters: a 32-bit address logged at 4 KiB grain, an 8-bit syndrome, a 1-bit channel and a 4-bit register offset. With these values every mapped and unmapped offset is reachable, including offset 0x00, which must read zero. A table of events walks the log through each ownership transition: empty to correctable, correctable to uncorrectable, and uncorrectable held. It also covers simultaneous pulses and clears that coincide with new events. Directed steps then check reset, the unmapped offsets, and writes to read-only offsets.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

   // register byte offsets
   localparam int OFF_PTR  = 0;
   localparam int OFF_SYN  = 4;
   localparam int OFF_CHAN = 5;
   localparam int OFF_STAT = 8;

   // status register layout
   localparam int STAT_W  = 16;
   localparam int CE_BIT  = 0;
   localparam int UE_BIT  = 7;
   localparam logic [STAT_W-1:0] STAT_IMPL = (STAT_W'(1) << CE_BIT) | (STAT_W'(1) << UE_BIT);

   typedef enum logic [1:0] {
      CAP_NONE = 2'd0,
      CAP_CE   = 2'd1,
      CAP_UE   = 2'd2
   } cap_sel_e;

endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status #(
   parameter int                  W    = 16,
   parameter logic [W-1:0]        IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] stat_o
);

   if (W < 1) begin : g_bad_w
      $error("ecc_log_status: W must be at least 1");
   end

   logic unused_inputs;
   assign unused_inputs = ^{set_i & ~IMPL, clr_i & ~IMPL};

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flop
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;
            else if (clr_i[i]) bit_q <= 1'b0;
         end
         assign stat_o[i] = bit_q;

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> stat_o[i]) else $error("event lost against clear"); // R12
         AST_STICKY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_o[i] && !clr_i[i]) |=> stat_o[i]) else $error("flag dropped"); // R4
         AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !stat_o[i]) else $error("clear ignored"); // R4
      end else begin : g_tie
         assign stat_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAIN_LSB = 12,
   parameter int SYN_W     = 8,
   parameter int CHAN_W    = 1,
   localparam int PG_W     = ADDR_W - GRAIN_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_pulse,
   input  logic              ue_pulse,
   input  logic [PG_W-1:0]   err_page,
   input  logic [SYN_W-1:0]  err_syn,
   input  logic [CHAN_W-1:0] err_chan,
   input  logic              ce_logged,
   input  logic              ue_logged,
   input  logic              ce_clr,
   input  logic              ue_clr,
   output logic [PG_W-1:0]   page_o,
   output logic [SYN_W-1:0]  syn_o,
   output logic [CHAN_W-1:0] chan_o
);

   if (PG_W < 1) begin : g_bad_grain
      $error("ecc_log_capture: GRAIN_LSB must be below ADDR_W");
   end

   logic     eff_ce, eff_ue;
   cap_sel_e sel;

   // ownership judged on flags after this cycle's clear
   always_comb begin
      eff_ce = ce_logged & ~ce_clr;
      eff_ue = ue_logged & ~ue_clr;
      sel    = CAP_NONE;
      if (ue_pulse && !eff_ue)
         sel = CAP_UE;
      else if (ce_pulse && !ue_pulse && !eff_ce && !eff_ue)
         sel = CAP_CE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_o <= '0;
         syn_o  <= '0;
         chan_o <= '0;
      end else if (sel != CAP_NONE) begin
         page_o <= err_page;
         syn_o  <= err_syn;
         chan_o <= err_chan;
      end
   end

   AST_CE_KEEPS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_pulse && !ue_pulse && (ce_logged || ue_logged) && !ce_clr && !ue_clr)
      |=> ($stable(page_o) && $stable(syn_o) && $stable(chan_o)))
      else $error("correctable event overwrote log"); // R9
   AST_UE_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_pulse && !(ue_logged && !ue_clr))
      |=> (page_o == $past(err_page) && syn_o == $past(err_syn) && chan_o == $past(err_chan)))
      else $error("uncorrectable event not captured"); // R8
   AST_UE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_logged && !ue_clr) |=> ($stable(page_o) && $stable(syn_o)))
      else $error("logged uncorrectable event displaced"); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_pulse && !ue_pulse) |=> ($stable(page_o) && $stable(syn_o) && $stable(chan_o)))
      else $error("log changed without event"); // R14

endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
   import ecc_log_pkg::*;
#(
   parameter int REG_AW    = 4,
   parameter int ADDR_W    = 32,
   parameter int GRAIN_LSB = 12,
   parameter int SYN_W     = 8,
   parameter int CHAN_W    = 1,
   parameter int SW        = 16,
   localparam int PG_W     = ADDR_W - GRAIN_LSB
) (
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [7:0]        reg_wdata,
   input  logic [PG_W-1:0]   page_i,
   input  logic [SYN_W-1:0]  syn_i,
   input  logic [CHAN_W-1:0] chan_i,
   input  logic [SW-1:0]     stat_i,
   output logic [7:0]        reg_rdata,
   output logic [SW-1:0]     stat_clr_o
);

   localparam int PTR_BYTES  = ADDR_W / 8;
   localparam int STAT_BYTES = SW / 8;
   localparam logic [REG_AW-1:0] A_PTR  = REG_AW'(OFF_PTR);
   localparam logic [REG_AW-1:0] A_SYN  = REG_AW'(OFF_SYN);
   localparam logic [REG_AW-1:0] A_CHAN = REG_AW'(OFF_CHAN);
   localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFF_STAT);

   if (ADDR_W % 8 != 0 || SW % 8 != 0) begin : g_bad_bytes
      $error("ecc_log_regs: ADDR_W and SW must be whole bytes");
   end
   if (SYN_W > 8 || CHAN_W > 8) begin : g_bad_fields
      $error("ecc_log_regs: syndrome and channel must fit one byte");
   end
   if (OFF_PTR + PTR_BYTES > OFF_SYN || OFF_STAT + STAT_BYTES > (1 << REG_AW)) begin : g_bad_map
      $error("ecc_log_regs: register map overlaps or exceeds offset space");
   end

   logic [ADDR_W-1:0] ptr;
   assign ptr = {page_i, {GRAIN_LSB{1'b0}}};

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < PTR_BYTES; b++) begin
         if (reg_addr == A_PTR + REG_AW'(b)) reg_rdata = ptr[8*b +: 8];
      end
      if (reg_addr == A_SYN)  reg_rdata[SYN_W-1:0]  = syn_i;
      if (reg_addr == A_CHAN) reg_rdata[CHAN_W-1:0] = chan_i;
      for (int b = 0; b < STAT_BYTES; b++) begin
         if (reg_addr == A_STAT + REG_AW'(b)) reg_rdata = stat_i[8*b +: 8];
      end
   end

   always_comb begin
      stat_clr_o = '0;
      for (int b = 0; b < STAT_BYTES; b++) begin
         if (reg_wr_en && reg_addr == A_STAT + REG_AW'(b)) stat_clr_o[8*b +: 8] = reg_wdata;
      end
   end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAIN_LSB = 12,
   parameter int SYN_W     = 8,
   parameter int CHAN_W    = 1,
   parameter int REG_AW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_pulse,
   input  logic              ue_pulse,
   input  logic [ADDR_W-1:0] err_addr,
   input  logic [SYN_W-1:0]  err_syn,
   input  logic [CHAN_W-1:0] err_chan,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata
);

   localparam int PG_W = ADDR_W - GRAIN_LSB;

   if (GRAIN_LSB < 0 || GRAIN_LSB >= ADDR_W) begin : g_bad_grain
      $error("ecc_err_log: GRAIN_LSB out of range");
   end

   logic unused_low;
   assign unused_low = ^err_addr[GRAIN_LSB-1:0];

   logic [STAT_W-1:0] stat, stat_set, stat_clr;
   logic [PG_W-1:0]   page;
   logic [SYN_W-1:0]  syn;
   logic [CHAN_W-1:0] chan;

   always_comb begin
      stat_set         = '0;
      stat_set[CE_BIT] = ce_pulse;
      stat_set[UE_BIT] = ue_pulse;
   end

   ecc_log_status #(.W(STAT_W), .IMPL(STAT_IMPL)) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (stat_set),
      .clr_i  (stat_clr),
      .stat_o (stat)
   );

   ecc_log_capture #(
      .ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W), .CHAN_W(CHAN_W)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_pulse  (ce_pulse),
      .ue_pulse  (ue_pulse),
      .err_page  (err_addr[ADDR_W-1:GRAIN_LSB]),
      .err_syn   (err_syn),
      .err_chan  (err_chan),
      .ce_logged (stat[CE_BIT]),
      .ue_logged (stat[UE_BIT]),
      .ce_clr    (stat_clr[CE_BIT]),
      .ue_clr    (stat_clr[UE_BIT]),
      .page_o    (page),
      .syn_o     (syn),
      .chan_o    (chan)
   );

   ecc_log_regs #(
      .REG_AW(REG_AW), .ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB),
      .SYN_W(SYN_W), .CHAN_W(CHAN_W), .SW(STAT_W)
   ) u_regs (
      .reg_addr   (reg_addr),
      .reg_wr_en  (reg_wr_en),
      .reg_wdata  (reg_wdata),
      .page_i     (page),
      .syn_i      (syn),
      .chan_i     (chan),
      .stat_i     (stat),
      .reg_rdata  (reg_rdata),
      .stat_clr_o (stat_clr)
   );

   AST_BOTH_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_pulse && ue_pulse) |=> (stat[CE_BIT] && stat[UE_BIT]))
      else $error("simultaneous events not both flagged"); // R11

endmodule

// File: tb/sim_ecc_err_log.sv
`timescale 1ns/1ps
module sim_ecc_err_log;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_pulse = 1'b0, ue_pulse = 1'b0;
   logic [31:0] err_addr = '0;
   logic [7:0]  err_syn = '0;
   logic [0:0]  err_chan = '0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ecc_err_log u0 (
      .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
      .err_addr(err_addr), .err_syn(err_syn), .err_chan(err_chan),
      .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   typedef struct packed {
      logic        ce;
      logic        ue;
      logic        wr;
      logic [7:0]  wd;
      logic [31:0] a;
      logic [7:0]  s;
      logic        c;
      logic [7:0]  est;
      logic [19:0] ehi;
      logic [7:0]  esyn;
      logic        ech;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,1'b0,8'h00,32'h1234_5678,8'h11,1'b1, 8'h01,20'h12345,8'h11,1'b1}, // R2 R7 empty log
      '{1'b1,1'b0,1'b0,8'h00,32'hAAAA_A000,8'h22,1'b0, 8'h01,20'h12345,8'h11,1'b1}, // R9
      '{1'b0,1'b1,1'b0,8'h00,32'h8765_4321,8'h33,1'b0, 8'h81,20'h87654,8'h33,1'b0}, // R3 R8
      '{1'b0,1'b1,1'b0,8'h00,32'h1111_1111,8'h44,1'b1, 8'h81,20'h87654,8'h33,1'b0}, // R10
      '{1'b1,1'b0,1'b0,8'h00,32'h2222_2222,8'h55,1'b1, 8'h81,20'h87654,8'h33,1'b0}, // R9
      '{1'b0,1'b0,1'b1,8'h01,32'h0,8'h00,1'b0,         8'h80,20'h87654,8'h33,1'b0}, // R4 R14
      '{1'b0,1'b0,1'b1,8'h80,32'h0,8'h00,1'b0,         8'h00,20'h87654,8'h33,1'b0}, // R4 R14
      '{1'b1,1'b1,1'b0,8'h00,32'hCAFE_B000,8'h66,1'b1, 8'h81,20'hCAFEB,8'h66,1'b1}, // R11
      '{1'b1,1'b0,1'b1,8'h81,32'h0BAD_F00D,8'h77,1'b0, 8'h01,20'h0BADF,8'h77,1'b0}, // R12 clear both + CE
      '{1'b0,1'b1,1'b1,8'h01,32'h5555_5FFF,8'h88,1'b1, 8'h80,20'h55555,8'h88,1'b1}, // R12 clear CE + UE
      '{1'b0,1'b0,1'b1,8'h00,32'h0,8'h00,1'b0,         8'h80,20'h55555,8'h88,1'b1}, // R4 zero write
      '{1'b1,1'b0,1'b1,8'h80,32'h7777_7777,8'h99,1'b0, 8'h01,20'h77777,8'h99,1'b0}  // R12 clear UE + CE
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic check_state(input string tag, input logic [7:0] est, input logic [19:0] ehi,
                              input logic [7:0] esyn, input logic ech);
      logic [7:0]  d;
      logic [31:0] ptr;
      rd(4'h8, d); chk(tag, "status low", {24'h0, d}, {24'h0, est});
      rd(4'h9, d); chk("R13", "status high", {24'h0, d}, 32'h0);
      for (int b = 0; b < 4; b++) begin
         rd(4'(b), d);
         ptr[8*b +: 8] = d;
      end
      chk({"R5 ", tag}, "pointer", ptr, {ehi, 12'h000});
      rd(4'h4, d); chk({"R6 ", tag}, "syndrome", {24'h0, d}, {24'h0, esyn});
      rd(4'h5, d); chk({"R6 ", tag}, "channel", {24'h0, d}, {31'h0, ech});
   endtask

   task automatic check_all_zero(input string req);
      logic [7:0] d;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         chk(req, $sformatf("offset %0h after reset", a), {24'h0, d}, 32'h0);
      end
   endtask

   initial begin
      int cyc;
      for (cyc = 0; cyc < 100000; cyc++) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      string vtag [NV];
      logic [7:0] d;
      vtag = '{"R2/R7", "R9", "R3/R8", "R10", "R9", "R4/R14", "R4/R14",
               "R11", "R12", "R12", "R4", "R12"};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all_zero("R1");

      // event table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ce_pulse = VECS[i].ce; ue_pulse = VECS[i].ue;
         err_addr = VECS[i].a;  err_syn = VECS[i].s; err_chan = VECS[i].c;
         if (VECS[i].wr) begin
            reg_addr = 4'h8; reg_wdata = VECS[i].wd; reg_wr_en = 1'b1;
         end
         @(negedge clk);
         ce_pulse = 1'b0; ue_pulse = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
         err_addr = 32'hDEAD_BEEF; err_syn = 8'hEE; err_chan = 1'b1;
         check_state(vtag[i], VECS[i].est, VECS[i].ehi, VECS[i].esyn, VECS[i].ech);
      end

      // R13 unmapped offsets read zero
      foreach (vtag[k]) begin end
      begin
         logic [3:0] un [8] = '{4'h6, 4'h7, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF};
         for (int k = 0; k < 8; k++) begin
            rd(un[k], d);
            chk("R13", $sformatf("unmapped %0h", un[k]), {24'h0, d}, 32'h0);
         end
      end

      // R13 writes to read-only offsets have no effect
      wr(4'h0, 8'hFF);
      wr(4'h2, 8'hFF);
      wr(4'h4, 8'hFF);
      wr(4'h5, 8'hFF);
      wr(4'h6, 8'hFF);
      check_state("R13", 8'h01, 20'h77777, 8'h99, 1'b0);

      // R4 write 0x81 clears both flags; R14 fields kept
      @(negedge clk); ue_pulse = 1'b1; err_addr = 32'h3333_3000; err_syn = 8'hAB; err_chan = 1'b1;
      @(negedge clk); ue_pulse = 1'b0;
      check_state("R8", 8'h81, 20'h33333, 8'hAB, 1'b1);
      wr(4'h8, 8'h81);
      check_state("R4/R14", 8'h00, 20'h33333, 8'hAB, 1'b1);

      // R1 reset in mid-run
      @(negedge clk); ce_pulse = 1'b1; err_addr = 32'h4444_4000; err_syn = 8'h12;
      @(negedge clk); ce_pulse = 1'b0;
      rd(4'h8, d); chk("R2", "status before reset", {24'h0, d}, 32'h01);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check_all_zero("R1");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule